// File: doc/BRIEF.md
# Banked GPIO Pad and Function-Select Controller

This block is the register-mapped control point for 56 general-purpose pads. The pads are grouped into three full banks of 16 pins and a final half bank of 8 pins. Software reaches the block over a plain 32-bit register bus with a byte address, a write strobe and combinational read data. For every pin it holds an output level, a direction, a two-bit function select, an open-drain control and a pull configuration. From these it drives the pad-side enable, value, function and pull signals. It also passes each pad's input level through a two-flop synchronizer into read-only input registers.

The pin-to-register mapping is regular: the bank is the pin number divided by 16 and the bit is the pin number modulo 16. The half bank breaks the 0x30-byte window stride for four of its registers. These sit in holes inside the windows of the first two banks. When a pin's function select is non-zero, the pad's value and enable come from that pin's alternate-function source instead of the GPIO registers. Open-drain and pull settings still apply.

Top module: `pad_bank_ctrl`

## Requirements
- R1: After reset every register reads zero, except the open-drain registers, which read all ones (0x0000FFFF for full banks, 0x000000FF for the half bank). Every padOe, padFunc, padPullUp and padPullDn bit is 0.
- R2: Full bank b (b = 0..2, pins 16b..16b+15) has its window at 0x30·b. Pin p occupies bit p mod 16 of its bank's registers. The offsets are: output +0x00, input +0x04, direction +0x08, function bit 0 +0x0C, function bit 1 +0x10, open-drain +0x14, pull select +0x1C, pull enable +0x20.
- R3: For the half bank (pins 48..55, bits 0..7), output, input, direction and function bit 0 are at 0x90, 0x94, 0x98 and 0x9C. Function bit 1 is at 0x54, open-drain at 0x24, pull select at 0x28 and pull enable at 0x2C.
- R4: An address that is not word aligned or not listed in R2/R3 (for example 0x18 or 0xA0) reads zero, and writes to it change nothing. Read bits above a bank's width are zero, and write data in them is dropped.
- R5: Input registers return padIn after two clock edges of synchronization. Writes to input offsets are ignored.
- R6: With function select 0, padOut follows the output bit and the pad drive enable follows the direction bit (1 = output, 0 = input).
- R7: padFunc[2p+1:2p] carries pin p's function select, made of {function bit 1, function bit 0}.
- R8: With a non-zero function select, pin p's drive value comes from altOut[p] and its enable from altOe[p]. The GPIO output and direction bits have no effect.
- R9: Open-drain bit 1 gives push-pull drive. Open-drain bit 0 asserts padOe only while the driven value is 0 and releases the pad when the value is 1.
- R10: A pull enable of 0 clears both pull outputs. A pull enable of 1 with pull select 1 raises padPullUp. A pull enable of 1 with pull select 0 raises padPullDn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| padIn | input | 56 | Pad input levels (asynchronous) |
| altOut | input | 56 | Alternate-function drive values |
| altOe | input | 56 | Alternate-function drive enables |
| padOut | output | 56 | Pad drive value |
| padOe | output | 56 | Pad drive enable |
| padFunc | output | 112 | Two-bit function select per pin |
| padPullUp | output | 56 | Pull-up enable per pin |
| padPullDn | output | 56 | Pull-down enable per pin |

## Verification
The bench targets the half bank's relocated registers. A decoder that followed the regular stride would answer at 0xA0 and leave 0x54 and 0x24..0x2C reading zero. It checks that a half-bank write of 0xFFFF reads back as 0xFF, which catches a design that keeps phantom bits 8..15. It times the input path edge by edge, so a missing or extra synchronizer stage shows up as data one cycle early or late. It also drives an open-drain pin high and low and switches a pin between GPIO and alternate modes while the unused source disagrees. A wrong polarity or a wrong mux leg therefore shows on padOe and padOut.

// File: rtl/padctl_pkg.sv
package padctl_pkg;
  localparam int PIN_COUNT  = 56;
  localparam int BANK_PINS  = 16;
  localparam int BANKS      = (PIN_COUNT + BANK_PINS - 1) / BANK_PINS;
  localparam int HALF_BANK  = BANKS - 1;
  localparam int HALF_PINS  = PIN_COUNT - HALF_BANK * BANK_PINS;
  localparam int BANK_IDX_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int WIN_STRIDE = 'h30;

  // offsets within a regular window
  localparam int OFS_OUT  = 'h00;
  localparam int OFS_IN   = 'h04;
  localparam int OFS_DIR  = 'h08;
  localparam int OFS_MUX0 = 'h0C;
  localparam int OFS_MUX1 = 'h10;
  localparam int OFS_OD   = 'h14;
  localparam int OFS_PSEL = 'h1C;
  localparam int OFS_PEN  = 'h20;

  // absolute addresses of the half bank's relocated registers
  localparam int HB_OD_ADDR   = 'h24;
  localparam int HB_PSEL_ADDR = 'h28;
  localparam int HB_PEN_ADDR  = 'h2C;
  localparam int HB_MUX1_ADDR = WIN_STRIDE + 'h24;

  typedef enum logic [2:0] {
    FLD_OUT, FLD_IN, FLD_DIR, FLD_MUX0, FLD_MUX1, FLD_OD, FLD_PSEL, FLD_PEN
  } fieldSel_e;

  typedef struct packed {
    logic                  hit;
    logic                  wr;
    fieldSel_e             field;
    logic [BANK_IDX_W-1:0] bank;
  } busStrobe_t;
endpackage

// File: rtl/padctl_decode.sv
module padctl_decode
  import padctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  fieldSel_e             fieldSel;
  logic                  fieldHit;
  logic [BANK_IDX_W-1:0] bankSel;

  always_comb begin
    fieldSel = FLD_OUT;
    fieldHit = 1'b0;
    bankSel  = '0;
    if (busAddr[1:0] == 2'b00) begin
      if (int'(busAddr) == HB_OD_ADDR) begin
        fieldSel = FLD_OD;   fieldHit = 1'b1; bankSel = BANK_IDX_W'(HALF_BANK);
      end else if (int'(busAddr) == HB_PSEL_ADDR) begin
        fieldSel = FLD_PSEL; fieldHit = 1'b1; bankSel = BANK_IDX_W'(HALF_BANK);
      end else if (int'(busAddr) == HB_PEN_ADDR) begin
        fieldSel = FLD_PEN;  fieldHit = 1'b1; bankSel = BANK_IDX_W'(HALF_BANK);
      end else if (int'(busAddr) == HB_MUX1_ADDR) begin
        fieldSel = FLD_MUX1; fieldHit = 1'b1; bankSel = BANK_IDX_W'(HALF_BANK);
      end else begin
        for (int b = 0; b < BANKS; b++) begin
          if (int'(busAddr) >= b * WIN_STRIDE && int'(busAddr) < (b + 1) * WIN_STRIDE) begin
            bankSel = BANK_IDX_W'(b);
            case (int'(busAddr) - b * WIN_STRIDE)
              OFS_OUT:  begin fieldSel = FLD_OUT;  fieldHit = 1'b1; end
              OFS_IN:   begin fieldSel = FLD_IN;   fieldHit = 1'b1; end
              OFS_DIR:  begin fieldSel = FLD_DIR;  fieldHit = 1'b1; end
              OFS_MUX0: begin fieldSel = FLD_MUX0; fieldHit = 1'b1; end
              OFS_MUX1: begin fieldSel = FLD_MUX1; fieldHit = (b != HALF_BANK); end
              OFS_OD:   begin fieldSel = FLD_OD;   fieldHit = (b != HALF_BANK); end
              OFS_PSEL: begin fieldSel = FLD_PSEL; fieldHit = (b != HALF_BANK); end
              OFS_PEN:  begin fieldSel = FLD_PEN;  fieldHit = (b != HALF_BANK); end
              default:  fieldHit = 1'b0;
            endcase
          end
        end
      end
    end
  end

  assign strobe.hit   = fieldHit;
  assign strobe.wr    = busWr && fieldHit && (fieldSel != FLD_IN);
  assign strobe.field = fieldSel;
  assign strobe.bank  = bankSel;

  // R4: only word-aligned addresses can decode
  assert_aligned_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hit |-> (busAddr[1:0] == 2'b00));

  // R3: half-bank hits only at its eight legal addresses
  assert_half_bank_map_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hit && strobe.bank == BANK_IDX_W'(HALF_BANK)) |->
      (busAddr inside {8'h24, 8'h28, 8'h2C, 8'h54, 8'h90, 8'h94, 8'h98, 8'h9C}));
endmodule

// File: rtl/padctl_regs.sv
module padctl_regs
  import padctl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  busStrobe_t             strobe,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  input  logic [PIN_COUNT-1:0]   padIn,
  input  logic [PIN_COUNT-1:0]   altOut,
  input  logic [PIN_COUNT-1:0]   altOe,
  output logic [PIN_COUNT-1:0]   padOut,
  output logic [PIN_COUNT-1:0]   padOe,
  output logic [2*PIN_COUNT-1:0] padFunc,
  output logic [PIN_COUNT-1:0]   padPullUp,
  output logic [PIN_COUNT-1:0]   padPullDn
);
  logic [PIN_COUNT-1:0] outReg, dirReg, mux0Reg, mux1Reg, odReg, pselReg, penReg;
  logic [PIN_COUNT-1:0] syncA, syncB;
  logic [PIN_COUNT-1:0] funcNz, drvVal, drvEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg  <= '0;
      dirReg  <= '0;
      mux0Reg <= '0;
      mux1Reg <= '0;
      odReg   <= '1;
      pselReg <= '0;
      penReg  <= '0;
    end else if (strobe.wr) begin
      for (int p = 0; p < PIN_COUNT; p++) begin
        if (strobe.bank == BANK_IDX_W'(p / BANK_PINS)) begin
          case (strobe.field)
            FLD_OUT:  outReg[p]  <= busWdata[p % BANK_PINS];
            FLD_DIR:  dirReg[p]  <= busWdata[p % BANK_PINS];
            FLD_MUX0: mux0Reg[p] <= busWdata[p % BANK_PINS];
            FLD_MUX1: mux1Reg[p] <= busWdata[p % BANK_PINS];
            FLD_OD:   odReg[p]   <= busWdata[p % BANK_PINS];
            FLD_PSEL: pselReg[p] <= busWdata[p % BANK_PINS];
            FLD_PEN:  penReg[p]  <= busWdata[p % BANK_PINS];
            default:  ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobe.hit) begin
      for (int p = 0; p < PIN_COUNT; p++) begin
        if (strobe.bank == BANK_IDX_W'(p / BANK_PINS)) begin
          case (strobe.field)
            FLD_OUT:  busRdata[p % BANK_PINS] = outReg[p];
            FLD_IN:   busRdata[p % BANK_PINS] = syncB[p];
            FLD_DIR:  busRdata[p % BANK_PINS] = dirReg[p];
            FLD_MUX0: busRdata[p % BANK_PINS] = mux0Reg[p];
            FLD_MUX1: busRdata[p % BANK_PINS] = mux1Reg[p];
            FLD_OD:   busRdata[p % BANK_PINS] = odReg[p];
            FLD_PSEL: busRdata[p % BANK_PINS] = pselReg[p];
            FLD_PEN:  busRdata[p % BANK_PINS] = penReg[p];
            default:  ;
          endcase
        end
      end
    end
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pad
    assign padFunc[2*p +: 2] = {mux1Reg[p], mux0Reg[p]};
    assign funcNz[p]    = mux1Reg[p] | mux0Reg[p];
    assign drvVal[p]    = funcNz[p] ? altOut[p] : outReg[p];
    assign drvEn[p]     = funcNz[p] ? altOe[p]  : dirReg[p];
    assign padOut[p]    = drvVal[p];
    assign padOe[p]     = drvEn[p] & (odReg[p] | ~drvVal[p]);
    assign padPullUp[p] = penReg[p] & pselReg[p];
    assign padPullDn[p] = penReg[p] & ~pselReg[p];
  end

  // cycles since reset, used only to window the synchronizer check
  logic [1:0] edgesSinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgesSinceRst <= '0;
    else if (edgesSinceRst != 2'd2) edgesSinceRst <= edgesSinceRst + 2'd1;
  end

  assert_reset_od_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> ((&odReg) && (outReg == '0) && (padOe == '0)));

  assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    (edgesSinceRst == 2'd2) |-> (syncB == $past(padIn, 2)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wr |=> ($stable(outReg) && $stable(dirReg) && $stable(odReg) &&
                    $stable(mux0Reg) && $stable(mux1Reg) && $stable(penReg) &&
                    $stable(pselReg)));

  assert_od_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & padOut & ~odReg) == '0));

  assert_alt_route_R8: assert property (@(posedge clk) disable iff (!rstN)
    (((padOut ^ altOut) & funcNz) == '0));

  assert_pull_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((padPullUp & padPullDn) == '0));
endmodule

// File: rtl/pad_bank_ctrl.sv
module pad_bank_ctrl
  import padctl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWr,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  input  logic [PIN_COUNT-1:0]   padIn,
  input  logic [PIN_COUNT-1:0]   altOut,
  input  logic [PIN_COUNT-1:0]   altOe,
  output logic [PIN_COUNT-1:0]   padOut,
  output logic [PIN_COUNT-1:0]   padOe,
  output logic [2*PIN_COUNT-1:0] padFunc,
  output logic [PIN_COUNT-1:0]   padPullUp,
  output logic [PIN_COUNT-1:0]   padPullDn
);
  busStrobe_t strobe;

  padctl_decode u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  padctl_regs u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .altOut    (altOut),
    .altOe     (altOe),
    .padOut    (padOut),
    .padOe     (padOe),
    .padFunc   (padFunc),
    .padPullUp (padPullUp),
    .padPullDn (padPullDn)
  );
endmodule

// File: tb/tb_pad_bank_ctrl.sv
module tb_pad_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 56;
  localparam int NVEC = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWr = 1'b0;
  logic [7:0]        busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [NPIN-1:0]   padIn = '0, altOut = '0, altOe = '0;
  logic [NPIN-1:0]   padOut, padOe, padPullUp, padPullDn;
  logic [2*NPIN-1:0] padFunc;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_bank_ctrl dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .altOut(altOut), .altOe(altOe), .padOut(padOut), .padOe(padOe),
    .padFunc(padFunc), .padPullUp(padPullUp), .padPullDn(padPullDn)
  );

  // {address, write data, expected readback}
  localparam logic [71:0] VECS [NVEC] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h0000_FFFF},  // R2 bank0 output, upper bits dropped
    {8'h08, 32'h0000_1234, 32'h0000_1234},  // R2 bank0 direction
    {8'h3C, 32'h0000_A5A5, 32'h0000_A5A5},  // R2 bank1 mux bit0
    {8'h40, 32'h0000_5A5A, 32'h0000_5A5A},  // R2 bank1 mux bit1
    {8'h74, 32'h0000_0F0F, 32'h0000_0F0F},  // R2 bank2 open-drain
    {8'h50, 32'h0000_8001, 32'h0000_8001},  // R2 bank1 pull enable
    {8'h7C, 32'h0000_C3C3, 32'h0000_C3C3},  // R2 bank2 pull select
    {8'h90, 32'h0000_FFFF, 32'h0000_00FF},  // R3 R4 half bank output, bits 8..15 dropped
    {8'h54, 32'h0000_01FF, 32'h0000_00FF},  // R3 half bank mux bit1
    {8'h24, 32'h0000_0000, 32'h0000_0000},  // R3 half bank open-drain
    {8'h28, 32'h0000_00C3, 32'h0000_00C3},  // R3 half bank pull select
    {8'h2C, 32'h0000_003C, 32'h0000_003C},  // R3 half bank pull enable
    {8'h18, 32'h0000_FFFF, 32'h0000_0000},  // R4 unmapped hole
    {8'hA0, 32'h0000_FFFF, 32'h0000_0000}   // R4 regular half-bank mux1 slot unmapped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  bit done = 1'b0;
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    doReset();

    // R1 reset state
    busRead(8'h00, rd); chk("R1 out reset", rd, 32'h0);
    busRead(8'h14, rd); chk("R1 od reset full bank", rd, 32'h0000_FFFF);
    busRead(8'h24, rd); chk("R1 od reset half bank", rd, 32'h0000_00FF);
    busRead(8'h98, rd); chk("R1 dir reset", rd, 32'h0);
    chk("R1 padOe reset", {8'h0, padOe[55:32]}, 32'h0);
    chk("R1 padFunc reset", {31'h0, |padFunc}, 32'h0);
    chk("R1 pulls reset", {30'h0, |padPullUp, |padPullDn}, 32'h0);

    // table: write then read back
    for (int i = 0; i < NVEC; i++) begin
      busWrite(VECS[i][71:64], VECS[i][63:32]);
      busRead(VECS[i][71:64], rd);
      chk($sformatf("R2 R3 R4 table vector %0d", i), rd, VECS[i][31:0]);
    end

    // R4: misaligned write ignored, unmapped writes leave neighbours alone
    busWrite(8'h00, 32'h0000_5A5A);
    busWrite(8'h02, 32'h0000_FFFF);
    busRead(8'h02, rd); chk("R4 misaligned read", rd, 32'h0);
    busRead(8'h00, rd); chk("R4 misaligned write ignored", rd, 32'h0000_5A5A);
    busRead(8'h54, rd); chk("R4 0xA0 write did not reach half mux1", rd, 32'h0000_00FF);
    busRead(8'h14, rd); chk("R4 0x18 write did not reach od", rd, 32'h0000_FFFF);

    // R5 input synchronizer timing and read-only behaviour
    doReset();
    @(negedge clk);
    padIn[3:0] = 4'hA; padIn[50:48] = 3'b101;
    @(negedge clk);
    busRead(8'h04, rd); chk("R5 one edge: not yet visible", rd, 32'h0);
    @(negedge clk);
    busRead(8'h04, rd); chk("R5 two edges: visible", rd, 32'h0000_000A);
    busRead(8'h94, rd); chk("R5 half bank input", rd, 32'h0000_0005);
    busWrite(8'h04, 32'h0000_FFFF);
    busRead(8'h04, rd); chk("R5 input write ignored", rd, 32'h0000_000A);

    // R6 GPIO push-pull
    busWrite(8'h08, 32'h0000_0001);
    busWrite(8'h00, 32'h0000_0001);
    chk("R6 gpio oe", {31'h0, padOe[0]}, 32'h1);
    chk("R6 gpio value", {31'h0, padOut[0]}, 32'h1);

    // R9 open drain
    busWrite(8'h14, 32'h0000_FFFE);
    chk("R9 od high releases", {31'h0, padOe[0]}, 32'h0);
    busWrite(8'h00, 32'h0000_0000);
    chk("R9 od low drives oe", {31'h0, padOe[0]}, 32'h1);
    chk("R9 od low value", {31'h0, padOut[0]}, 32'h0);

    // R8/R7 alternate function on half-bank pin 49 (bit 1)
    altOut[49] = 1'b1; altOe[49] = 1'b1;
    #1;
    chk("R8 gpio mode ignores alt oe", {31'h0, padOe[49]}, 32'h0);
    busWrite(8'h9C, 32'h0000_0002);
    chk("R7 func=1 on pin 49", {30'h0, padFunc[99:98]}, 32'h1);
    busWrite(8'h54, 32'h0000_0002);
    chk("R7 func=3 on pin 49", {30'h0, padFunc[99:98]}, 32'h3);
    chk("R8 alt oe routed", {31'h0, padOe[49]}, 32'h1);
    chk("R8 alt value routed", {31'h0, padOut[49]}, 32'h1);
    busWrite(8'h90, 32'h0000_0000);
    chk("R8 gpio out has no effect", {31'h0, padOut[49]}, 32'h1);

    // R10 pulls on pin 20 (bank1 bit 4)
    busWrite(8'h4C, 32'h0000_0010);
    chk("R10 pull off while disabled", {30'h0, padPullUp[20], padPullDn[20]}, 32'h0);
    busWrite(8'h50, 32'h0000_0010);
    chk("R10 pull up", {30'h0, padPullUp[20], padPullDn[20]}, 32'h2);
    busWrite(8'h4C, 32'h0000_0000);
    chk("R10 pull down", {30'h0, padPullUp[20], padPullDn[20]}, 32'h1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule